// File: doc/BRIEF.md
# Triggered Three-Crossing Readout Buffer

This block sits behind the detector inputs and records, on every clock, one crossing's worth of trigger bits and hit bits into a circular pipeline. When a level-1 accept arrives, the block captures three neighbouring crossings from that pipeline. The crossing one latency back is the triggered one, and the block also takes the crossing just before it and the crossing just after it. It labels the capture with the running event number and with the crossing number of the triggered crossing.

Each capture waits in a short queue until a serialiser is free. The serialiser then sends it as one frame on a single data line. A frame-valid strobe is high for exactly the bits of each frame. The clock, the two counter resets and the accept all come from the timing distribution system. The latency is a static input that the user sets before accepts are issued.

Top module: `xrb_readout`

## Requirements
- R1: The bunch counter reads 0 in the cycle where `bc_clr` is sampled high and advances by one on every following clock (12 bits, wrapping).
- R2: The event counter reads 0 in the cycle where `ev_clr` is sampled high. Each accept is tagged with the current counter value, and the counter then advances by one. An accept sampled together with `ev_clr` is therefore tagged 0.
- R3: With latency L (2 to DEPTH-2), an accept sampled at clock edge s captures the crossings whose inputs were sampled at edges s-L-1 (previous), s-L (current) and s-L+1 (next).
- R4: The crossing tag equals the bunch counter value at the accept edge minus L, modulo 4096.
- R5: A frame is 24 + 3*(TRG_W+HIT_W) bits long and is sent MSB first. It carries the 12-bit event tag, then the 12-bit crossing tag, then the previous, current and next crossings. Inside each crossing the TRG_W trigger bits come before the HIT_W hit bits.
- R6: When the queue is empty and the serialiser is idle, an accept at edge s makes `frame_vld` rise after edge s+1. The first frame bit appears on `ser_out` at that point, and one new bit follows after each edge for the length of the frame.
- R7: The queue holds QDEPTH captures that have not yet started sending. An accept sampled while the queue is full is dropped, and `drop_flag` is high for the one cycle after that edge. A dropped accept still advances the event counter.
- R8: Queued frames go out back to back. `frame_vld` stays high, with no idle cycle, from the first bit of one frame to the last bit of the next.
- R9: After reset, and whenever no frame is being sent, `ser_out`, `frame_vld` and `drop_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock from the timing system |
| rst_n | input | 1 | Synchronous active-low reset |
| bc_clr | input | 1 | Bunch counter reset |
| ev_clr | input | 1 | Event counter reset |
| accept | input | 1 | Level-1 accept |
| l1_lat | input | $clog2(DEPTH) | Trigger latency in clocks |
| hits | input | HIT_W | Hit bits of the current crossing |
| trig | input | TRG_W | Trigger bits of the current crossing |
| ser_out | output | 1 | Serial frame data, MSB first |
| frame_vld | output | 1 | High during every frame bit |
| drop_flag | output | 1 | One-cycle pulse after a dropped accept |

## Verification
An accept at edge s is due on `ser_out` starting after edge s+1 when the serialiser is idle. A queued frame starts exactly one frame length after the frame ahead of it, and `drop_flag` is due after the edge that sampled the rejected accept. The bench counts clock edges and keeps the sampled edge index for every stimulus. It shifts in frame bits at falling edges and compares both the frame content and its starting edge with values derived from those indices. It sweeps the latency over its whole legal range and covers a bunch reset just before an accept, so that the crossing tag wraps. It also covers an event reset in the same cycle as an accept, and a burst one longer than the queue.

// File: rtl/xrb_pkg.sv
// Shared constants and helpers for the three-crossing readout buffer.
// Assumes the identifier width is fixed by the readout format.
package xrb_pkg;
    localparam int ID_W = 12;

    // Frame length: two identifiers plus three crossings.
    function automatic int frame_len(input int trg_w, input int hit_w);
        return 2 * ID_W + 3 * (trg_w + hit_w);
    endfunction
endpackage

// File: rtl/xrb_cnt.sv
// Clearable counter with a combinational "now" value.
// Assumes clr takes priority over inc in the same cycle.
module xrb_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] now
);
    logic [W-1:0] cnt_q;

    // Value seen by this cycle: zero when cleared.
    always_comb now = clr ? '0 : cnt_q;

    // Advance from the current value.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= now + W'(inc);
    end
endmodule

// File: rtl/xrb_pipe.sv
// Circular pipeline memory that stores one crossing per clock.
// Provides three read ports for the crossings around the triggered one.
// Assumes DEPTH is a power of two and 2 <= lat <= DEPTH-2.
module xrb_pipe #(
    parameter int XW    = 200,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] din,
    input  logic [AW-1:0] lat,
    output logic [XW-1:0] prev_x,
    output logic [XW-1:0] cur_x,
    output logic [XW-1:0] next_x
);
    logic [XW-1:0] mem [DEPTH];
    logic [AW-1:0] wp;

    // Write pointer advances every clock once out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) wp <= '0;
        else        wp <= wp + AW'(1);
    end

    // Store the crossing sampled at this edge.
    always_ff @(posedge clk) begin
        mem[wp] <= din;
    end

    // Read the three crossings one latency back from the write slot.
    always_comb begin
        prev_x = mem[wp - lat - AW'(1)];
        cur_x  = mem[wp - lat];
        next_x = mem[wp - lat + AW'(1)];
    end
endmodule

// File: rtl/xrb_fifo.sv
// Small first-in first-out queue of complete captures.
// Assumes the caller never pushes when full and never pops when empty.
module xrb_fifo #(
    parameter int W     = 624,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic [LW-1:0] level
);
    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wr_p, rd_p;

    // Store the incoming capture.
    always_ff @(posedge clk) begin
        if (push) slot[wr_p] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p  <= '0;
            rd_p  <= '0;
            level <= '0;
        end else begin
            if (push) wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + PW'(1);
            if (pop)  rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + PW'(1);
            level <= level + LW'(push) - LW'(pop);
        end
    end

    // Oldest capture is always presented.
    always_comb dout = slot[rd_p];
endmodule

// File: rtl/xrb_ser.sv
// Parallel-to-serial frame sender, MSB first, with a valid strobe.
// Reloads on the last bit so that queued frames follow without a gap.
module xrb_ser #(
    parameter int FW  = 624,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          avail,
    input  logic [FW-1:0] din,
    output logic          take,
    output logic          sd,
    output logic          vld
);
    logic [FW-1:0] sreg;
    logic [CW-1:0] left;
    logic          busy;

    // Accept a new frame when idle or on the final bit.
    always_comb take = avail && (!busy || left == CW'(1));

    // Shift state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            left <= '0;
            busy <= 1'b0;
        end else if (take) begin
            sreg <= din;
            left <= CW'(FW);
            busy <= 1'b1;
        end else if (busy) begin
            sreg <= {sreg[FW-2:0], 1'b0};
            left <= left - CW'(1);
            busy <= (left != CW'(1));
        end
    end

    // Drive the line only while a frame is in flight.
    always_comb begin
        sd  = busy & sreg[FW-1];
        vld = busy;
    end
endmodule

// File: rtl/xrb_readout.sv
// Top level: pipeline, counters, capture queue and serial sender.
// Assumes l1_lat is held steady and within 2..DEPTH-2 while accepts occur.
module xrb_readout #(
    parameter int HIT_W  = 160,
    parameter int TRG_W  = 40,
    parameter int DEPTH  = 128,
    parameter int QDEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int ID_W  = xrb_pkg::ID_W,
    localparam int XW    = TRG_W + HIT_W,
    localparam int FW    = xrb_pkg::frame_len(TRG_W, HIT_W),
    localparam int QW    = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bc_clr,
    input  logic             ev_clr,
    input  logic             accept,
    input  logic [AW-1:0]    l1_lat,
    input  logic [HIT_W-1:0] hits,
    input  logic [TRG_W-1:0] trig,
    output logic             ser_out,
    output logic             frame_vld,
    output logic             drop_flag
);
    logic [ID_W-1:0] bc_cur, ev_cur, bc_tag;
    logic [XW-1:0]   prev_x, cur_x, next_x;
    logic [FW-1:0]   cap, head;
    logic [QW-1:0]   q_level;
    logic            q_full, q_push, q_pop;

    xrb_cnt #(.W(ID_W)) u_bc (
        .clk(clk), .rst_n(rst_n), .clr(bc_clr), .inc(1'b1), .now(bc_cur)
    );

    xrb_cnt #(.W(ID_W)) u_ev (
        .clk(clk), .rst_n(rst_n), .clr(ev_clr), .inc(accept), .now(ev_cur)
    );

    xrb_pipe #(.XW(XW), .DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .din({trig, hits}), .lat(l1_lat),
        .prev_x(prev_x), .cur_x(cur_x), .next_x(next_x)
    );

    // Assemble the capture and decide whether the queue can take it.
    always_comb begin
        bc_tag = bc_cur - ID_W'(l1_lat);
        cap    = {ev_cur, bc_tag, prev_x, cur_x, next_x};
        q_full = (q_level == QW'(QDEPTH));
        q_push = accept && !q_full;
    end

    xrb_fifo #(.W(FW), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(cap),
        .pop(q_pop), .dout(head), .level(q_level)
    );

    xrb_ser #(.FW(FW)) u_ser (
        .clk(clk), .rst_n(rst_n), .avail(q_level != '0), .din(head),
        .take(q_pop), .sd(ser_out), .vld(frame_vld)
    );

    // One-cycle pulse for an accept lost to a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_flag <= 1'b0;
        else        drop_flag <= accept && q_full;
    end
endmodule

// File: rtl/xrb_readout_chk.sv
// Property checker for xrb_readout, attached through bind.
// Observes counters, queue level and the serial strobe.
module xrb_readout_chk #(
    parameter int ID_W   = 12,
    parameter int QDEPTH = 4,
    parameter int QW     = 3,
    parameter int FW     = 624,
    localparam int CW    = $clog2(FW + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bc_clr,
    input logic            ev_clr,
    input logic            accept,
    input logic            frame_vld,
    input logic            drop_flag,
    input logic [QW-1:0]   q_level,
    input logic [ID_W-1:0] bc_cur,
    input logic [ID_W-1:0] ev_cur
);
    logic [CW-1:0] run;

    // Position inside the current frame, wrapping at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         run <= '0;
        else if (frame_vld) run <= (run == CW'(FW - 1)) ? '0 : run + CW'(1);
    end

    a_r1_bc_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bc_clr || bc_cur == ID_W'($past(bc_cur) + 1'b1)));

    a_r2_ev_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ev_clr || ev_cur == ID_W'($past(ev_cur) + ID_W'($past(accept)))));

    a_r7_q_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= QW'(QDEPTH));

    a_r7_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        drop_flag |-> ($past(accept) && $past(q_level) == QW'(QDEPTH)));

    a_r7_drop_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && q_level == QW'(QDEPTH)) |=> drop_flag);

    // R6, R8: the strobe only drops on a whole-frame boundary.
    a_r6_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |-> run == '0);
endmodule

bind xrb_readout xrb_readout_chk #(
    .ID_W(ID_W), .QDEPTH(QDEPTH), .QW(QW), .FW(FW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bc_clr(bc_clr), .ev_clr(ev_clr),
    .accept(accept), .frame_vld(frame_vld), .drop_flag(drop_flag),
    .q_level(q_level), .bc_cur(bc_cur), .ev_cur(ev_cur)
);

// File: tb/xrb_readout_test.sv
// Self-checking bench for xrb_readout on a reduced configuration.
module xrb_readout_test;
    localparam int HIT_W = 16;
    localparam int TRG_W = 8;
    localparam int DEPTH = 16;
    localparam int QD    = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam int XW    = TRG_W + HIT_W;
    localparam int FW    = 24 + 3 * XW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bc_clr = 1'b0, ev_clr = 1'b0, accept = 1'b0;
    logic [AW-1:0]    l1_lat = AW'(2);
    logic [HIT_W-1:0] hits = '0;
    logic [TRG_W-1:0] trig = '0;
    logic ser_out, frame_vld, drop_flag;

    xrb_readout #(.HIT_W(HIT_W), .TRG_W(TRG_W), .DEPTH(DEPTH), .QDEPTH(QD)) uut (
        .clk(clk), .rst_n(rst_n), .bc_clr(bc_clr), .ev_clr(ev_clr),
        .accept(accept), .l1_lat(l1_lat), .hits(hits), .trig(trig),
        .ser_out(ser_out), .frame_vld(frame_vld), .drop_flag(drop_flag)
    );

    always #10 clk = ~clk;   // 50 MHz

    int total = 0, bad = 0;
    int eg = 0;              // number of rising edges so far
    int s_bcr = 0, ev_model = 0;
    logic [FW-1:0] exp_f [64];
    int exp_s [64];
    int nexp = 0, fidx = 0, bitn = 0, fstart = 0, idle_err = 0;
    logic [FW-1:0] got = '0;

    always @(posedge clk) eg <= eg + 1;

    // Crossing content for the input sampled at a given edge.
    function automatic logic [XW-1:0] pat(input int s);
        logic [31:0] h;
        h = (s * 32'h9E3779B1) ^ (s << 11) ^ 32'h00005A5A;
        return XW'(h);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Present the crossing that the next edge will sample.
    always @(negedge clk) {trig, hits} = pat(eg + 1);

    // Collect frames and compare content and start edge (R3 R4 R5 R6 R8).
    always @(negedge clk) begin
        if (frame_vld) begin
            if (bitn == 0) fstart = eg;
            got = {got[FW-2:0], ser_out};
            bitn++;
            if (bitn == FW) begin
                total++;
                if (fidx >= nexp || got != exp_f[fidx]) begin
                    bad++;
                    $display("FAIL R3/R4/R5 frame %0d actual=%h expected=%h",
                             fidx, got, (fidx < nexp) ? exp_f[fidx] : '0);
                end
                chk(fidx < nexp && fstart == exp_s[fidx], "R6/R8 start", fstart,
                    (fidx < nexp) ? exp_s[fidx] : -1);
                bitn = 0;
                fidx++;
            end
        end else if (ser_out) begin
            idle_err++;
        end
    end

    task automatic quiet();
        @(negedge clk);
        accept = 1'b0; ev_clr = 1'b0; bc_clr = 1'b0;
    endtask

    task automatic pulse_bcr();
        @(negedge clk);
        bc_clr = 1'b1; s_bcr = eg + 1;
        quiet();
    endtask

    // Issue an accept in the next cycle; leaves accept high.
    task automatic do_accept(input int L, input bit with_clr, input bit kept, input int off);
        int s, id, bc;
        @(negedge clk);
        s = eg + 1;
        l1_lat = AW'(L);
        accept = 1'b1;
        ev_clr = with_clr;
        id = with_clr ? 0 : ev_model;
        ev_model = id + 1;
        bc = (s - s_bcr - L) & 12'hFFF;
        if (kept) begin
            exp_f[nexp] = {12'(id), 12'(bc), pat(s - L - 1), pat(s - L), pat(s - L + 1)};
            exp_s[nexp] = s + off;
            nexp++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!frame_vld && !ser_out && !drop_flag, "R9 reset", {frame_vld, ser_out, drop_flag}, 0);
        rst_n = 1'b1;
        pulse_bcr();
        @(negedge clk); ev_clr = 1'b1; ev_model = 0;
        quiet();
        repeat (30) @(negedge clk);
        chk(!frame_vld && !ser_out, "R9 idle", frame_vld, 0);

        // R3 R4 R5 R6: every legal latency, single accepts.
        for (int L = 2; L <= DEPTH - 2; L++) begin
            do_accept(L, 1'b0, 1'b1, 1);
            quiet();
            chk(!drop_flag, "R7 no drop", drop_flag, 0);
            repeat (FW + 8) @(negedge clk);
        end

        // R2: event clear together with an accept, then one more.
        do_accept(6, 1'b1, 1'b1, 1);
        quiet();
        repeat (FW + 8) @(negedge clk);
        do_accept(6, 1'b0, 1'b1, 1);
        quiet();
        repeat (FW + 8) @(negedge clk);

        // R1 R4: bunch reset shortly before an accept, tag wraps below zero.
        pulse_bcr();
        @(negedge clk);
        do_accept(10, 1'b0, 1'b1, 1);
        quiet();
        repeat (FW + 8) @(negedge clk);

        // R7 R8: burst one longer than the queue; the last is dropped.
        for (int i = 0; i < QD + 2; i++) begin
            if (i == QD + 1) chk(!drop_flag, "R7 before full", drop_flag, 0);
            do_accept(5, 1'b0, i <= QD, 1 + i * (FW - 1));
        end
        quiet();
        chk(drop_flag == 1'b1, "R7 drop pulse", drop_flag, 1);
        @(negedge clk);
        chk(!drop_flag, "R7 pulse width", drop_flag, 0);
        repeat ((QD + 1) * FW + 8) @(negedge clk);

        // R7: the dropped accept still consumed an event number.
        do_accept(3, 1'b0, 1'b1, 1);
        quiet();
        repeat (FW + 8) @(negedge clk);

        chk(fidx == nexp, "R7 frame count", fidx, nexp);
        chk(idle_err == 0, "R9 line idle", idle_err, 0);
        chk(!frame_vld, "R6 end of frames", frame_vld, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule